// File: doc/BRIEF.md
# Level-Triggered Pre/Post Sample Capture

The block records a window of tagged ADC samples around a level trigger. Each sample is a 12-bit signed code. It carries two tags: a one-bit attenuation flag, where 1 means the path was divided by 16, and a two-bit sensor range. Once armed, the block writes every valid sample into a circular on-block memory. It waits until a programmed number of pre-trigger samples has been stored. It then looks for a rising crossing of a programmed level, stores a programmed number of post-trigger samples, and stops.

The trigger comparison uses a gain-corrected value, so an attenuator switch between two samples does not produce a false crossing or mask a real one. When the record is complete, the block raises a done flag and presents the record's first address. A downstream consumer drains the record through a read port addressed by offset from that start. A force input triggers without a level crossing, and an abort input drops the capture.

The settings are sampled when the block is armed: level, pre-trigger count and post-trigger count. The record is pre + 1 + post words long, and that length must not exceed the memory depth.

Top module: `trig_capture`

## Requirements
- R1: Each stored word is {range[1:0], atten, code[11:0]}: bits 14:13 hold the range, bit 12 the attenuation flag, bits 11:0 the code.
- R2: An arm pulse is accepted only in idle or done. The first valid sample after an accepted arm goes to address 0, and each further valid sample goes to the next address modulo the depth. Cycles with sample_valid_i low write nothing.
- R3: For triggering, a sample with atten=1 is taken as its sign-extended code shifted left by 4, and a sample with atten=0 as its sign-extended code. This 16-bit signed value is compared with the signed 16-bit trig_level_i.
- R4: A trigger needs the previous valid sample below the level and the current one at or above it. The first sample after arming never triggers, and a signal that stays above the level never triggers.
- R5: Sample k (counted from 0 after arming) can trigger only when k >= pre count; earlier crossings are ignored.
- R6: After the trigger sample, exactly post-count further samples are stored. done_o then rises on the following cycle and stays high, and later samples are not written.
- R7: start_addr_o equals (trigger sample index - pre count) modulo the depth.
- R8: A read request with offset i returns the word at (start_addr_o + i) modulo the depth on rd_data_o, with rd_valid_o high, one cycle later.
- R9: While waiting for a trigger, force_trig_i makes the current valid sample, or the next one if none is present, the trigger sample regardless of level.
- R10: abort_i returns the block to idle with done_o low, and later samples trigger nothing. A later arm starts a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_valid_i | input | 1 | Sample present this cycle |
| sample_code_i | input | 12 | Signed ADC code |
| sample_atten_i | input | 1 | 1 = divide-by-16 path |
| sample_range_i | input | 2 | Sensor range tag |
| trig_level_i | input | 16 | Signed gain-corrected trigger level |
| pre_count_i | input | 8 | Samples kept before the trigger |
| post_count_i | input | 8 | Samples kept after the trigger |
| arm_i | input | 1 | Start a capture |
| force_trig_i | input | 1 | Software trigger |
| abort_i | input | 1 | Cancel capture |
| done_o | output | 1 | Record complete |
| start_addr_o | output | 8 | First address of the record |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 8 | Offset within the record |
| rd_data_o | output | 15 | Stored word |
| rd_valid_o | output | 1 | Read data valid |

## Verification
A wrong write pointer or a wrong pre-count latch shows up at the ports as a shifted record. done_o stays correct, but the words drained from start_addr_o are offset from the samples fed in, and this appears on the first read after done. A fault in gain correction or edge detection moves the trigger index. That changes start_addr_o and the cycle on which done_o rises, which is post-count samples after the intended trigger. A state machine that keeps writing after done corrupts the record with samples fed after completion, so the directed runs keep feeding samples past the end of every record.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;
  localparam int CODE_W_DEF  = 12;
  localparam int RANGE_W_DEF = 2;
  localparam int ADDR_W_DEF  = 8;
  localparam int SHIFT_DEF   = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FILL = 3'd1,
    ST_WAIT = 3'd2,
    ST_POST = 3'd3,
    ST_DONE = 3'd4
  } cap_state_e;
endpackage

// File: rtl/cap_level_cmp.sv
module cap_level_cmp #(
  parameter int CODE_W = 12,
  parameter int SHIFT  = 4,
  localparam int LVL_W = CODE_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              atten_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic              edge_o
);
  logic signed [LVL_W-1:0] raw_ext, corr, prev_q, lvl;
  logic                    prev_ok_q;

  assign raw_ext = LVL_W'($signed(code_i));
  assign lvl     = $signed(level_i);

  generate
    if (SHIFT == 0) begin : g_noscale
      assign corr = raw_ext;
    end else begin : g_scale
      assign corr = atten_i ? (raw_ext <<< SHIFT) : raw_ext;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else if (clear_i) begin
      prev_ok_q <= 1'b0;
    end else if (wr_en_i) begin
      prev_q    <= corr;
      prev_ok_q <= 1'b1;
    end
  end

  assign edge_o = prev_ok_q && (prev_q < lvl) && (corr >= lvl);

  AST_FIRST_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !edge_o) // R4
    else $error("edge right after arm");
endmodule

// File: rtl/cap_sample_ram.sv
module cap_sample_ram #(
  parameter int WORD_W = 15,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) rdata_o <= mem[raddr_i];
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rvalid_o) // R8
    else $error("read valid missing");
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import trig_capture_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 16,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic              edge_i,
  input  logic              arm_i,
  input  logic              force_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] pre_count_i,
  input  logic [ADDR_W-1:0] post_count_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic [LVL_W-1:0]  level_o,
  output logic              clear_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] start_addr_o
);
  cap_state_e        state_q;
  logic [ADDR_W-1:0] wr_ptr_q, pre_q, post_q, post_cnt_q, start_q;
  logic [CNT_W-1:0]  fill_cnt_q, fill_next;
  logic [LVL_W-1:0]  level_q;
  logic              force_pend_q;
  logic              capturing, arm_ok, trig_fire;

  assign capturing = (state_q == ST_FILL) || (state_q == ST_WAIT) || (state_q == ST_POST);
  assign arm_ok    = !abort_i && arm_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign wr_en_o   = sample_valid_i && capturing && !abort_i;
  assign trig_fire = wr_en_o && (state_q == ST_WAIT) && (edge_i || force_i || force_pend_q);
  assign fill_next = fill_cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      wr_ptr_q     <= '0;
      fill_cnt_q   <= '0;
      pre_q        <= '0;
      post_q       <= '0;
      post_cnt_q   <= '0;
      start_q      <= '0;
      level_q      <= '0;
      force_pend_q <= 1'b0;
    end else if (abort_i) begin
      state_q      <= ST_IDLE;
      force_pend_q <= 1'b0;
    end else if (arm_ok) begin
      state_q      <= (pre_count_i == '0) ? ST_WAIT : ST_FILL;
      wr_ptr_q     <= '0;
      fill_cnt_q   <= '0;
      pre_q        <= pre_count_i;
      post_q       <= post_count_i;
      level_q      <= level_i;
      force_pend_q <= 1'b0;
    end else begin
      if (wr_en_o) begin
        wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
        if (fill_cnt_q != '1) fill_cnt_q <= fill_next;
      end
      unique case (state_q)
        ST_FILL: begin
          if (wr_en_o && (fill_next >= {1'b0, pre_q})) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (trig_fire) begin
            start_q      <= wr_ptr_q - pre_q;
            post_cnt_q   <= '0;
            force_pend_q <= 1'b0;
            state_q      <= (post_q == '0) ? ST_DONE : ST_POST;
          end else if (force_i) begin
            force_pend_q <= 1'b1;
          end
        end
        ST_POST: begin
          if (wr_en_o) begin
            post_cnt_q <= post_cnt_q + ADDR_W'(1);
            if (post_cnt_q + ADDR_W'(1) == post_q) state_q <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign clear_o      = arm_ok;
  assign level_o      = level_q;
  assign wr_addr_o    = wr_ptr_q;
  assign done_o       = (state_q == ST_DONE);
  assign start_addr_o = start_q;

  AST_WR_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> (wr_ptr_q == $past(wr_ptr_q) + ADDR_W'(1))) // R2
    else $error("write pointer skipped");
  AST_TRIG_AFTER_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_fire |-> (fill_cnt_q >= {1'b0, pre_q})) // R5
    else $error("trigger inside pre window");
  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_fire |=> (start_q == $past(wr_ptr_q - pre_q))) // R7
    else $error("start address wrong");
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i && !abort_i) |=> (done_o && $stable(start_q))) // R6
    else $error("done dropped");
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE)) // R10
    else $error("abort ignored");
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_capture_pkg::*;
#(
  parameter int CODE_W  = CODE_W_DEF,
  parameter int RANGE_W = RANGE_W_DEF,
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int SHIFT   = SHIFT_DEF,
  localparam int LVL_W  = CODE_W + SHIFT,
  localparam int WORD_W = RANGE_W + 1 + CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic [CODE_W-1:0]  sample_code_i,
  input  logic               sample_atten_i,
  input  logic [RANGE_W-1:0] sample_range_i,
  input  logic [LVL_W-1:0]   trig_level_i,
  input  logic [ADDR_W-1:0]  pre_count_i,
  input  logic [ADDR_W-1:0]  post_count_i,
  input  logic               arm_i,
  input  logic               force_trig_i,
  input  logic               abort_i,
  output logic               done_o,
  output logic [ADDR_W-1:0]  start_addr_o,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               rd_valid_o
);
  logic              edge_w, clear_w, wr_en_w;
  logic [LVL_W-1:0]  level_w;
  logic [ADDR_W-1:0] wr_addr_w;
  logic [WORD_W-1:0] wr_word;

  assign wr_word = {sample_range_i, sample_atten_i, sample_code_i};

  cap_ctrl #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk_i, .rst_ni,
    .sample_valid_i,
    .edge_i       (edge_w),
    .arm_i,
    .force_i      (force_trig_i),
    .abort_i,
    .pre_count_i,
    .post_count_i,
    .level_i      (trig_level_i),
    .level_o      (level_w),
    .clear_o      (clear_w),
    .wr_en_o      (wr_en_w),
    .wr_addr_o    (wr_addr_w),
    .done_o,
    .start_addr_o
  );

  cap_level_cmp #(.CODE_W(CODE_W), .SHIFT(SHIFT)) u_cmp (
    .clk_i, .rst_ni,
    .clear_i (clear_w),
    .wr_en_i (wr_en_w),
    .code_i  (sample_code_i),
    .atten_i (sample_atten_i),
    .level_i (level_w),
    .edge_o  (edge_w)
  );

  cap_sample_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i, .rst_ni,
    .we_i     (wr_en_w),
    .waddr_i  (wr_addr_w),
    .wdata_i  (wr_word),
    .re_i     (rd_en_i),
    .raddr_i  (start_addr_o + rd_idx_i),
    .rdata_o  (rd_data_o),
    .rvalid_o (rd_valid_o)
  );

  AST_DONE_STOPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !wr_en_w) // R6
    else $error("write after done");
endmodule

// File: tb/trig_capture_tb_top.sv
`timescale 1ns/1ps
module trig_capture_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        s_valid = 0, s_atten = 0, arm = 0, force_t = 0, abort = 0, rd_en = 0;
  logic [11:0] s_code = '0;
  logic [1:0]  s_range = '0;
  logic [15:0] level = '0;
  logic [7:0]  pre = '0, post = '0, rd_idx = '0, start_addr;
  logic        done, rd_valid;
  logic [14:0] rd_data;
  logic [14:0] stim [0:399];
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  trig_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(s_valid), .sample_code_i(s_code),
    .sample_atten_i(s_atten), .sample_range_i(s_range), .trig_level_i(level),
    .pre_count_i(pre), .post_count_i(post), .arm_i(arm), .force_trig_i(force_t),
    .abort_i(abort), .done_o(done), .start_addr_o(start_addr), .rd_en_i(rd_en),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(input int code, input bit att, input int rng);
    return {rng[1:0], att, code[11:0]};
  endfunction

  function automatic int corr(input logic [14:0] w);
    int v = $signed(w[11:0]);
    return w[12] ? v * 16 : v;
  endfunction

  // R3 R4 R5 reference: first eligible rising crossing
  function automatic int exp_trig(input int p, input int lvl, input int n);
    for (int k = 1; k < n; k++)
      if (k >= p && corr(stim[k-1]) < lvl && corr(stim[k]) >= lvl) return k;
    return -1;
  endfunction

  task automatic arm_cfg(input int p, input int q, input int lvl);
    @(negedge clk);
    pre = p[7:0]; post = q[7:0]; level = lvl[15:0]; arm = 1;
    @(negedge clk);
    arm = 0;
  endtask

  task automatic drive(input int k);
    s_valid = 1; {s_range, s_atten, s_code} = stim[k];
  endtask

  task automatic feed(input int from, input int n, input bit gaps);
    for (int k = from; k < from + n; k++) begin
      drive(k);
      @(negedge clk);
      s_valid = 0;
      if (gaps && (k % 3 == 2)) @(negedge clk);
    end
    s_valid = 0;
  endtask

  task automatic check_record(input int trig, input int p, input int q, input string req);
    for (int i = 0; i < p + q + 1; i++) begin
      rd_en = 1; rd_idx = i[7:0];
      @(negedge clk);
      check(rd_valid && rd_data == stim[trig - p + i], req, rd_data, stim[trig - p + i]);
    end
    rd_en = 0;
  endtask

  task automatic run_std(input int p, input int q, input int lvl, input int n,
                         input bit gaps, input string req);
    int t;
    arm_cfg(p, q, lvl);
    feed(0, n, gaps);
    t = exp_trig(p, lvl, n);
    check(done == 1'b1, {req, " R6 done"}, done, 1);
    check(start_addr == 8'((t - p) & 255), {req, " R7 start"}, start_addr, (t - p) & 255);
    check_record(t, p, q, {req, " R1 R6 R8 record"});
  endtask

  task automatic t_reset();
    check(done == 0, "R6 reset done", done, 0);
    check(start_addr == 0, "R7 reset start", start_addr, 0);
    check(rd_valid == 0, "R8 reset rd_valid", rd_valid, 0);
  endtask

  task automatic t_basic();
    for (int k = 0; k < 40; k++) stim[k] = mk((k * 37) % 900, 0, k % 4);
    stim[10] = mk(1200, 0, 3);
    run_std(4, 5, 1000, 40, 1'b1, "R2 basic");
  endtask

  task automatic t_gain();
    for (int k = 0; k < 20; k++) stim[k] = mk(500, 0, 1);
    stim[2] = mk(50, 1, 2);   // 800 < 1000
    stim[3] = mk(70, 0, 0);   // raw 70 must not count as 1120
    stim[4] = mk(900, 0, 2);
    stim[5] = mk(70, 1, 3);   // 1120 crosses
    run_std(3, 2, 1000, 20, 1'b0, "R3 gain");
  endtask

  task automatic t_signed_zero();
    for (int k = 0; k < 10; k++) stim[k] = mk(-5, 1, 2);
    stim[0] = mk(-2000, 0, 1);
    run_std(0, 0, -100, 10, 1'b0, "R3 R4 signed pre0 post0");
  endtask

  task automatic t_pre_gate();
    for (int k = 0; k < 20; k++) stim[k] = mk(0, 0, 0);
    stim[1] = mk(2000, 0, 1);
    stim[3] = mk(2000, 0, 1);
    stim[6] = mk(2000, 0, 2);
    run_std(5, 2, 1000, 20, 1'b0, "R5 pre gate");
    check(start_addr == 1, "R5 trig at 6", start_addr, 1);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 320; k++) stim[k] = mk((k * 7) % 900, 0, k % 4);
    stim[300] = mk(1200, 0, 1);
    run_std(10, 3, 1000, 320, 1'b0, "R2 wrap");
  endtask

  task automatic t_force();
    for (int k = 0; k < 12; k++) stim[k] = mk(1500, 0, k % 4);
    arm_cfg(2, 2, 1000);
    feed(0, 6, 1'b0);
    check(done == 0, "R4 no edge when above", done, 0);
    force_t = 1; drive(6);
    @(negedge clk);
    force_t = 0; s_valid = 0;
    feed(7, 5, 1'b0);
    check(done == 1, "R9 force done", done, 1);
    check(start_addr == 4, "R9 force start", start_addr, 4);
    check_record(6, 2, 2, "R9 force record");
  endtask

  task automatic t_abort();
    for (int k = 0; k < 10; k++) stim[k] = mk((k % 2) ? 2000 : 0, 0, 1);
    arm_cfg(1, 1, 1000);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    feed(0, 10, 1'b0);
    check(done == 0, "R10 abort no done", done, 0);
    run_std(1, 1, 1000, 10, 1'b0, "R10 rearm");
    check(start_addr == 0, "R10 rearm start", start_addr, 0);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gain();
    t_signed_zero();
    t_pre_gate();
    t_wrap();
    t_force();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule